// File: doc/BRIEF.md
# PCI Bus Latency Violation Monitor

This block sits on the host arbiter's side of a shared PCI bus. It samples the active-low control lines FRAME#, IRDY#, TRDY# and STOP# on each rising clock edge and follows every transaction phase by phase. For each data phase it counts how many clocks the target takes to answer with TRDY# or STOP#. It also counts how many clocks the master takes to drive IRDY#.

The target limit is 16 clocks for the first data phase and 8 clocks for each later phase. The master limit is 8 clocks in every phase. A response that arrives on the last allowed clock is compliant and is not flagged. A response that arrives one clock later is a violation. Each violation sets a sticky status bit, one for the target and one for the master. A mask register enables each status bit onto a single interrupt line. Software reads both registers through a small write/read port and clears status bits by writing 1 to them.

Top module: `pci_lat_mon`

## Requirements
- R1: After reset the status register reads 0, the mask register reads 0 and irq_o is low.
- R2: The first data phase is counted from the edge where FRAME# is first sampled low. A target answering on edge 16 after that edge sets no status bit. A target still silent at edge 17 sets status bit 12.
- R3: A later data phase is counted from the edge where the previous phase completed. A target answering on edge 8 sets nothing. A target answering on edge 9 or later sets bit 12.
- R4: In the first data phase, a master asserting IRDY# on edge 8 after FRAME# sets nothing. A master asserting IRDY# on edge 9 or later sets status bit 11.
- R5: In a later data phase, a master asserting IRDY# on edge 8 after the previous phase completed sets nothing. A master asserting IRDY# on edge 9 or later sets bit 11.
- R6: STOP# ends the target wait exactly as TRDY# does, with the same limits.
- R7: Status bits stay set until a write to the status register (reg_sel_i=0) carries 1 in that bit position. Writing 0 to a bit leaves it unchanged.
- R8: The mask register (reg_sel_i=1) holds enable bits at positions 12 (target) and 11 (master). irq_o is high exactly when some status bit is set and its enable bit is 1.
- R9: Latency counting restarts at every completed data phase (IRDY# low together with TRDY# or STOP#). Time spent in one phase never carries into the next.
- R10: Control-line activity outside a transaction sets no bit. Only bits 12 and 11 exist; every other read bit is 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | FRAME#, active low |
| irdy_ni | input | 1 | IRDY#, active low |
| trdy_ni | input | 1 | TRDY#, active low |
| stop_ni | input | 1 | STOP#, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| irq_o | output | 1 | Masked bus timeout interrupt |

## Verification
Each check is tied to a clock edge at the ports. A counter that is off by one misjudges the boundary responses at 16/17 and 8/9. That error appears as a wrong status read straight after the transaction. If the phase tracker misses a phase completion, the count carries into the next phase and produces a false bit after a multi-phase burst of compliant phases. A wrong mask or status register is visible on irq_o or on the read port in the cycle after the write.

// File: rtl/pci_lat_pkg.sv
package pci_lat_pkg;
  localparam int TGT_BIT = 12;
  localparam int MST_BIT = 11;
  localparam int CH_MST  = 0;
  localparam int CH_TGT  = 1;
  localparam int N_CH    = 2;

  typedef enum logic {
    BUS_IDLE = 1'b0,
    BUS_BUSY = 1'b1
  } bus_st_e;
endpackage

// File: rtl/pci_phase_trk.sv
module pci_phase_trk
  import pci_lat_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_ni,
  input  logic irdy_ni,
  input  logic trdy_ni,
  input  logic stop_ni,
  output logic busy_o,
  output logic first_o,
  output logic step_o,
  output logic restart_o
);
  bus_st_e st_q;
  logic    first_q;
  logic    start, done, abort;

  assign start = (st_q == BUS_IDLE) && !frame_ni;
  assign done  = (st_q == BUS_BUSY) && !irdy_ni && (!trdy_ni || !stop_ni);
  // master gave up without a final data phase
  assign abort = (st_q == BUS_BUSY) && frame_ni && irdy_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BUS_IDLE;
      first_q <= 1'b0;
    end else begin
      case (st_q)
        BUS_IDLE: if (start) begin
          st_q    <= BUS_BUSY;
          first_q <= 1'b1;
        end
        default: if (done) begin
          first_q <= 1'b0;
          if (frame_ni) st_q <= BUS_IDLE;
        end else if (abort) begin
          st_q <= BUS_IDLE;
        end
      endcase
    end
  end

  assign busy_o    = (st_q == BUS_BUSY);
  assign first_o   = first_q;
  assign step_o    = (st_q == BUS_BUSY);
  assign restart_o = start || done || abort;
endmodule

// File: rtl/pci_lat_cnt.sv
module pci_lat_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             step_i,
  input  logic             rsp_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             viol_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             seen_q;

  assign cnt_nxt = cnt_q + CNT_W'(1);
  // edge lim+1 reached with no earlier answer: late, flagged once
  assign viol_o  = step_i && !seen_q && (cnt_nxt == lim_i + CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (step_i) begin
      seen_q <= seen_q || rsp_i;
      if (!seen_q && (cnt_q <= lim_i)) cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/pci_lat_regs.sv
module pci_lat_regs
  import pci_lat_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] set_i,
  input  logic [N_CH-1:0] clr_i,
  input  logic            mask_we_i,
  input  logic [N_CH-1:0] mask_d_i,
  output logic [N_CH-1:0] stat_o,
  output logic [N_CH-1:0] mask_o,
  output logic            irq_o
);
  logic [N_CH-1:0] stat_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_i) | set_i;  // new event wins over clear
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & mask_q);
endmodule

// File: rtl/pci_lat_mon.sv
module pci_lat_mon
  import pci_lat_pkg::*;
#(
  parameter int TGT_FIRST_LIM = 16,
  parameter int DATA_LIM      = 8,
  parameter int REG_W         = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ni,
  input  logic             irdy_ni,
  input  logic             trdy_ni,
  input  logic             stop_ni,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  localparam int MAX_LIM = (TGT_FIRST_LIM > DATA_LIM) ? TGT_FIRST_LIM : DATA_LIM;
  localparam int CNT_W   = $clog2(MAX_LIM + 2);

  logic            busy, first, step, restart;
  logic [N_CH-1:0] rsp, viol, clr_bits, mask_d, stat_q, mask_q;
  logic [CNT_W-1:0] lim [N_CH];
  logic            unused_wdata;

  pci_phase_trk u_trk (
    .clk_i, .rst_ni, .frame_ni, .irdy_ni, .trdy_ni, .stop_ni,
    .busy_o(busy), .first_o(first), .step_o(step), .restart_o(restart)
  );

  assign rsp[CH_TGT] = !trdy_ni || !stop_ni;
  assign rsp[CH_MST] = !irdy_ni;
  assign lim[CH_TGT] = first ? CNT_W'(TGT_FIRST_LIM) : CNT_W'(DATA_LIM);
  assign lim[CH_MST] = CNT_W'(DATA_LIM);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pci_lat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_ni,
      .restart_i(restart), .step_i(step), .rsp_i(rsp[c]),
      .lim_i(lim[c]), .viol_o(viol[c])
    );
  end

  assign clr_bits[CH_TGT] = reg_wr_i && !reg_sel_i && reg_wdata_i[TGT_BIT];
  assign clr_bits[CH_MST] = reg_wr_i && !reg_sel_i && reg_wdata_i[MST_BIT];
  assign mask_d[CH_TGT]   = reg_wdata_i[TGT_BIT];
  assign mask_d[CH_MST]   = reg_wdata_i[MST_BIT];
  assign unused_wdata     = ^reg_wdata_i;

  pci_lat_regs u_regs (
    .clk_i, .rst_ni,
    .set_i(viol), .clr_i(clr_bits),
    .mask_we_i(reg_wr_i && reg_sel_i), .mask_d_i(mask_d),
    .stat_o(stat_q), .mask_o(mask_q), .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata_o          = '0;
    reg_rdata_o[TGT_BIT] = reg_sel_i ? mask_q[CH_TGT] : stat_q[CH_TGT];
    reg_rdata_o[MST_BIT] = reg_sel_i ? mask_q[CH_MST] : stat_q[CH_MST];
  end
endmodule

// File: rtl/pci_lat_mon_chk.sv
module pci_lat_mon_chk
  import pci_lat_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            irq_o,
  input logic            reg_wr_i,
  input logic            reg_sel_i,
  input logic            busy_i,
  input logic [N_CH-1:0] viol_i,
  input logic [N_CH-1:0] clr_i,
  input logic [N_CH-1:0] stat_i,
  input logic [N_CH-1:0] mask_i
);
  AST_TGT_SET_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni) viol_i[CH_TGT] |=> stat_i[CH_TGT]); // R2
  AST_MST_SET_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni) viol_i[CH_MST] |=> stat_i[CH_MST]); // R4
  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) (stat_i[CH_TGT] && !clr_i[CH_TGT]) |=> stat_i[CH_TGT]); // R7
  AST_MASK_GATES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni) (mask_i == '0) |-> !irq_o); // R8
  AST_MASK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni) !(reg_wr_i && reg_sel_i) |=> $stable(mask_i)); // R8
  AST_ONE_SHOT_PER_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni) viol_i[CH_TGT] |=> !viol_i[CH_TGT]); // R9
  AST_NO_SET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !busy_i |-> (viol_i == '0)); // R10
endmodule

bind pci_lat_mon pci_lat_mon_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o),
  .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
  .busy_i(busy), .viol_i(viol), .clr_i(clr_bits),
  .stat_i(stat_q), .mask_i(mask_q)
);

// File: tb/sim_pci_lat_mon.sv
module sim_pci_lat_mon;
  localparam int TGT_FIRST = 16;
  localparam int DLIM      = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done_flag = 1'b0;

  typedef struct {
    logic [15:0] exp;
    bit          is_irq;
    string       tag;
  } item_t;
  item_t q[$];
  event  sample_ev;

  always #2 clk = ~clk;

  pci_lat_mon u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .frame_ni(frame_n), .irdy_ni(irdy_n), .trdy_ni(trdy_n), .stop_ni(stop_n),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  // monitor: pops expected items and compares with the port values
  initial begin
    forever begin
      @(sample_ev);
      #1;
      if (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = q.pop_front();
        act = it.is_irq ? {15'b0, irq} : reg_rdata;
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_reg(input bit sel, input logic [15:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    reg_sel = sel;
    it.exp = exp; it.is_irq = 1'b0; it.tag = tag;
    q.push_back(it);
    -> sample_ev;
  endtask

  task automatic expect_irq(input bit exp, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = {15'b0, exp}; it.is_irq = 1'b1; it.tag = tag;
    q.push_back(it);
    -> sample_ev;
  endtask

  task automatic wr(input bit sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // response edges counted from the phase start edge (edge 0)
  task automatic txn(input int nph, input int t0, input int m0,
                     input int tn, input int mn, input bit use_stop);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
    for (int p = 0; p < nph; p++) begin
      int tw, mw, kmax;
      bit last;
      tw   = (p == 0) ? t0 : tn;
      mw   = (p == 0) ? m0 : mn;
      kmax = (tw > mw) ? tw : mw;
      last = (p == nph - 1);
      for (int k = 1; k <= kmax; k++) begin
        @(negedge clk);
        irdy_n = !(k >= mw);
        if (use_stop) stop_n = !(k >= tw);
        else          trdy_n = !(k >= tw);
        frame_n = last && (k >= mw);
      end
    end
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
  endtask

  function automatic logic [15:0] exp_stat(input int nph, input int t0, input int m0,
                                           input int tn, input int mn);
    logic [15:0] r;
    r = '0;
    if (t0 > TGT_FIRST || (nph > 1 && tn > DLIM)) r[12] = 1'b1;
    if (m0 > DLIM || (nph > 1 && mn > DLIM))      r[11] = 1'b1;
    return r;
  endfunction

  task automatic run(input int nph, input int t0, input int m0, input int tn,
                     input int mn, input bit use_stop, input string tag);
    wr(1'b0, 16'h1800);
    txn(nph, t0, m0, tn, mn, use_stop);
    expect_reg(1'b0, exp_stat(nph, t0, m0, tn, mn), tag);
  endtask

  initial begin
    #(4 * 50000);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_reg(1'b0, 16'h0000, "R1 status after reset");
    expect_reg(1'b1, 16'h0000, "R1 mask after reset");
    expect_irq(1'b0, "R1 irq after reset");

    run(1, 16, 8, 0, 0, 1'b0, "R2 target first phase at 16");
    run(1, 17, 8, 0, 0, 1'b0, "R2 target first phase at 17");
    expect_irq(1'b0, "R8 irq masked off");
    wr(1'b1, 16'h1000);
    expect_reg(1'b1, 16'h1000, "R8 mask readback");
    expect_irq(1'b1, "R8 irq enabled target");
    wr(1'b1, 16'h0800);
    expect_irq(1'b0, "R8 irq other enable only");

    wr(1'b0, 16'h0800);
    expect_reg(1'b0, 16'h1000, "R7 clear other bit keeps");
    wr(1'b0, 16'h0000);
    expect_reg(1'b0, 16'h1000, "R7 write zero keeps");
    wr(1'b0, 16'h1000);
    expect_reg(1'b0, 16'h0000, "R7 write one clears");

    run(1, 16, 8, 0, 0, 1'b1, "R6 stop at 16");
    run(1, 17, 8, 0, 0, 1'b1, "R6 stop at 17");

    run(1, 2, 8, 0, 0, 1'b0, "R4 master first at 8");
    run(1, 2, 9, 0, 0, 1'b0, "R4 master first at 9");
    expect_irq(1'b1, "R8 irq enabled master");

    run(3, 2, 2, 8, 8, 1'b0, "R3 R5 later phases at 8");
    run(3, 2, 2, 9, 2, 1'b0, "R3 target later at 9");
    run(3, 2, 2, 2, 9, 1'b0, "R5 master later at 9");
    run(2, 16, 8, 8, 8, 1'b0, "R9 count restarts per phase");
    run(2, 17, 9, 2, 2, 1'b0, "R2 R4 both flagged");

    wr(1'b0, 16'hE7FF);
    expect_reg(1'b0, 16'h1800, "R10 unimplemented bits read 0");
    wr(1'b1, 16'hFFFF);
    expect_reg(1'b1, 16'h1800, "R10 mask only two bits");
    wr(1'b0, 16'h1800);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      irdy_n = i[0]; trdy_n = i[1]; stop_n = i[2];
    end
    @(negedge clk);
    irdy_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
    expect_reg(1'b0, 16'h0000, "R10 idle activity ignored");
    expect_irq(1'b0, "R10 no irq after idle activity");

    repeat (4) @(negedge clk);
    done_flag = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule